// File: doc/BRIEF.md
# Byte-Merging Operand Bypass Network

This block sits between the register file read ports and the execution units of a machine with two symmetric in-order execution sides. Each side reads up to three source registers per instruction. Writes are predicated per byte lane, so the newest bytes of one register may be held partly in the first execute stage, partly in the writeback stage and partly in the register file. The block assembles every source operand lane by lane from those three places. The register file is assumed to pass data being written in the same cycle straight through to its read ports, so two pipeline stages are the only bypass sources needed.

Each in-flight result occupies a producer slot. The slot index is `stage*N_SIDE + side`, where stage 0 is the first execute stage and stage 1 is writeback. A slot carries a valid bit, a destination register, a byte-enable mask, data, a ready bit and a tag. The tag is unique among in-flight results of one side. The block remembers which tags were ready at the previous clock edge. This lets it apply the rule that a result can be read on its own side as soon as it is ready, but on the opposite side only from the cycle after it first became ready. When a needed byte is not yet usable, the block raises a single stall request that holds issue on both sides.

Top module: `opbyp_merge`

## Requirements
- R1: A byte lane that no valid producer slot claims takes its value from the register file read data of that operand.
- R2: Merging is per byte lane. Bit b of a slot's byte-enable mask covers data bits 8b+7..8b, so one operand may combine bytes from several slots and the register file.
- R3: When slots in both stages claim a lane, the first execute stage (stage 0) wins over writeback (stage 1).
- R4: When both sides' slots in the same stage claim a lane, the side 1 slot wins.
- R5: A ready result read by a consumer on the same side never causes a stall.
- R6: A ready result read from the opposite side stalls in its first ready cycle. It stops stalling once the same tag was seen ready on that producer side at the previous clock edge, in either stage.
- R7: A lane whose winning producer is not ready raises the stall, whichever side consumes it.
- R8: A source whose read enable is low never contributes to the stall, although its operand is still merged.
- R9: Register number 0 is forwarded exactly like any other register.
- R10: Reset clears the record of ready tags, so the first cycle after reset treats every opposite-side result as newly ready.
- R11: A slot with its valid bit low is ignored, even when its destination and mask match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | N_SIDE*N_SRC | Read enable per operand; operand k = side*N_SRC + src |
| rd_reg | input | N_SIDE*N_SRC*REG_W | Source register number per operand |
| rd_rf | input | N_SIDE*N_SRC*DATA_W | Register file read data per operand |
| pr_vld | input | 2*N_SIDE | Producer slot valid |
| pr_dst | input | 2*N_SIDE*REG_W | Producer destination register |
| pr_ben | input | 2*N_SIDE*DATA_W/8 | Producer byte-enable mask |
| pr_data | input | 2*N_SIDE*DATA_W | Producer result data |
| pr_rdy | input | 2*N_SIDE | Producer result available this cycle |
| pr_tag | input | 2*N_SIDE*TAG_W | Producer tag, unique per side |
| opnd | output | N_SIDE*N_SRC*DATA_W | Merged operands |
| stall | output | 1 | Stall request for both sides |

## Verification
The only internal state is the record of which tags were ready at the last edge. If that record is wrong, it shows on `stall` in the same cycle that an opposite-side consumer reads such a result. It can show as a missing first-cycle stall or as a stall that does not clear on the following cycle. A wrong lane selection shows at once on `opnd` as bytes from the wrong slot. The bench therefore compares every operand and the stall on every cycle, and holds producer slots for varied numbers of cycles so that the ready record is exercised across stage moves.

// File: rtl/opbyp_pkg.sv
package opbyp_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned N_STG  = 2;
endpackage

// File: rtl/opbyp_rdy_track.sv
module opbyp_rdy_track #(
  parameter int unsigned N_SIDE = 2,
  parameter int unsigned TAG_W  = 4,
  localparam int unsigned N_SLOT = N_SIDE * opbyp_pkg::N_STG
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SLOT-1:0]       pr_vld,
  input  logic [N_SLOT-1:0]       pr_rdy,
  input  logic [N_SLOT*TAG_W-1:0] pr_tag,
  output logic [N_SLOT-1:0]       rdy_old
);
  logic [N_SLOT-1:0]       seen_q, seen_d;
  logic [N_SLOT*TAG_W-1:0] tag_q;

  assign seen_d = pr_vld & pr_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= seen_d;
  end

  for (genvar s = 0; s < N_SLOT; s++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          tag_q[s*TAG_W +: TAG_W] <= '0;
      else if (seen_d[s])  tag_q[s*TAG_W +: TAG_W] <= pr_tag[s*TAG_W +: TAG_W];
    end
  end

  always_comb begin
    for (int s = 0; s < int'(N_SLOT); s++) begin
      rdy_old[s] = 1'b0;
      for (int q = 0; q < int'(N_SLOT); q++) begin
        if ((q % int'(N_SIDE)) == (s % int'(N_SIDE)) && seen_q[q] &&
            tag_q[q*TAG_W +: TAG_W] == pr_tag[s*TAG_W +: TAG_W])
          rdy_old[s] = pr_vld[s] & pr_rdy[s];
      end
    end
  end
endmodule

// File: rtl/opbyp_lane_pick.sv
module opbyp_lane_pick #(
  parameter int unsigned N_SIDE    = 2,
  parameter int unsigned REG_W     = 6,
  parameter int unsigned CONS_SIDE = 0,
  localparam int unsigned N_SLOT = N_SIDE * opbyp_pkg::N_STG,
  localparam int unsigned LW     = opbyp_pkg::LANE_W
) (
  input  logic [REG_W-1:0]        src_reg,
  input  logic [N_SLOT-1:0]       pr_vld,
  input  logic [N_SLOT-1:0]       pr_lane_en,
  input  logic [N_SLOT-1:0]       pr_rdy,
  input  logic [N_SLOT-1:0]       pr_rdy_old,
  input  logic [N_SLOT*REG_W-1:0] pr_dst,
  input  logic [N_SLOT*LW-1:0]    pr_byte,
  input  logic [LW-1:0]           rf_byte,
  output logic [LW-1:0]           lane_out,
  output logic                    lane_wait
);
  logic          hit, usable;
  logic [LW-1:0] pick;

  // lowest priority first, later hits overwrite earlier ones
  always_comb begin
    hit    = 1'b0;
    usable = 1'b1;
    pick   = rf_byte;
    for (int st = int'(opbyp_pkg::N_STG) - 1; st >= 0; st--) begin
      for (int sd = 0; sd < int'(N_SIDE); sd++) begin
        if (pr_vld[st*int'(N_SIDE)+sd] && pr_lane_en[st*int'(N_SIDE)+sd] &&
            pr_dst[(st*int'(N_SIDE)+sd)*int'(REG_W) +: REG_W] == src_reg) begin
          hit    = 1'b1;
          pick   = pr_byte[(st*int'(N_SIDE)+sd)*int'(LW) +: LW];
          usable = (sd == int'(CONS_SIDE)) ? pr_rdy[st*int'(N_SIDE)+sd]
                                           : pr_rdy_old[st*int'(N_SIDE)+sd];
        end
      end
    end
    lane_out  = pick;
    lane_wait = hit & ~usable;
  end
endmodule

// File: rtl/opbyp_operand.sv
module opbyp_operand #(
  parameter int unsigned N_SIDE    = 2,
  parameter int unsigned REG_W     = 6,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned CONS_SIDE = 0,
  localparam int unsigned N_SLOT = N_SIDE * opbyp_pkg::N_STG,
  localparam int unsigned LW     = opbyp_pkg::LANE_W,
  localparam int unsigned LANES  = DATA_W / LW
) (
  input  logic [REG_W-1:0]         src_reg,
  input  logic [DATA_W-1:0]        rf_word,
  input  logic [N_SLOT-1:0]        pr_vld,
  input  logic [N_SLOT-1:0]        pr_rdy,
  input  logic [N_SLOT-1:0]        pr_rdy_old,
  input  logic [N_SLOT*REG_W-1:0]  pr_dst,
  input  logic [N_SLOT*LANES-1:0]  pr_ben,
  input  logic [N_SLOT*DATA_W-1:0] pr_data,
  output logic [DATA_W-1:0]        word_out,
  output logic                     word_wait
);
  logic [LANES-1:0] lane_wait;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [N_SLOT-1:0]    en_b;
    logic [N_SLOT*LW-1:0] byte_b;
    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
      assign en_b[s]              = pr_ben[s*LANES + b];
      assign byte_b[s*LW +: LW]   = pr_data[s*DATA_W + b*LW +: LW];
    end
    opbyp_lane_pick #(.N_SIDE(N_SIDE), .REG_W(REG_W), .CONS_SIDE(CONS_SIDE)) pick_i (
      .src_reg   (src_reg),
      .pr_vld    (pr_vld),
      .pr_lane_en(en_b),
      .pr_rdy    (pr_rdy),
      .pr_rdy_old(pr_rdy_old),
      .pr_dst    (pr_dst),
      .pr_byte   (byte_b),
      .rf_byte   (rf_word[b*LW +: LW]),
      .lane_out  (word_out[b*LW +: LW]),
      .lane_wait (lane_wait[b])
    );
  end

  assign word_wait = |lane_wait;
endmodule

// File: rtl/opbyp_merge.sv
module opbyp_merge #(
  parameter int unsigned N_SIDE = 2,
  parameter int unsigned N_SRC  = 3,
  parameter int unsigned REG_W  = 6,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned N_SLOT = N_SIDE * opbyp_pkg::N_STG,
  localparam int unsigned N_OP   = N_SIDE * N_SRC,
  localparam int unsigned LANES  = DATA_W / opbyp_pkg::LANE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_OP-1:0]          rd_en,
  input  logic [N_OP*REG_W-1:0]    rd_reg,
  input  logic [N_OP*DATA_W-1:0]   rd_rf,
  input  logic [N_SLOT-1:0]        pr_vld,
  input  logic [N_SLOT*REG_W-1:0]  pr_dst,
  input  logic [N_SLOT*LANES-1:0]  pr_ben,
  input  logic [N_SLOT*DATA_W-1:0] pr_data,
  input  logic [N_SLOT-1:0]        pr_rdy,
  input  logic [N_SLOT*TAG_W-1:0]  pr_tag,
  output logic [N_OP*DATA_W-1:0]   opnd,
  output logic                     stall
);
  logic [N_SLOT-1:0] rdy_old;
  logic [N_OP-1:0]   op_wait;

  opbyp_rdy_track #(.N_SIDE(N_SIDE), .TAG_W(TAG_W)) track_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pr_vld (pr_vld),
    .pr_rdy (pr_rdy),
    .pr_tag (pr_tag),
    .rdy_old(rdy_old)
  );

  for (genvar sd = 0; sd < N_SIDE; sd++) begin : g_side
    for (genvar sr = 0; sr < N_SRC; sr++) begin : g_src
      localparam int unsigned K = sd*N_SRC + sr;
      opbyp_operand #(.N_SIDE(N_SIDE), .REG_W(REG_W), .DATA_W(DATA_W),
                      .CONS_SIDE(sd)) op_i (
        .src_reg   (rd_reg[K*REG_W +: REG_W]),
        .rf_word   (rd_rf[K*DATA_W +: DATA_W]),
        .pr_vld    (pr_vld),
        .pr_rdy    (pr_rdy),
        .pr_rdy_old(rdy_old),
        .pr_dst    (pr_dst),
        .pr_ben    (pr_ben),
        .pr_data   (pr_data),
        .word_out  (opnd[K*DATA_W +: DATA_W]),
        .word_wait (op_wait[K])
      );
    end
  end

  assign stall = |(op_wait & rd_en);
endmodule

// File: rtl/opbyp_merge_chk.sv
module opbyp_merge_chk #(
  parameter int unsigned N_SIDE = 2,
  parameter int unsigned N_SRC  = 3,
  parameter int unsigned REG_W  = 6,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned N_SLOT = N_SIDE * 2,
  localparam int unsigned N_OP   = N_SIDE * N_SRC,
  localparam int unsigned LANES  = DATA_W / 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_OP-1:0]          rd_en,
  input logic [N_OP*REG_W-1:0]    rd_reg,
  input logic [N_OP*DATA_W-1:0]   rd_rf,
  input logic [N_SLOT-1:0]        pr_vld,
  input logic [N_SLOT*REG_W-1:0]  pr_dst,
  input logic [N_SLOT*LANES-1:0]  pr_ben,
  input logic [N_SLOT-1:0]        pr_rdy,
  input logic [N_SLOT*TAG_W-1:0]  pr_tag,
  input logic [N_OP*DATA_W-1:0]   opnd,
  input logic                     stall
);
  localparam int unsigned TOP = N_SIDE - 1; // stage 0, last side: highest priority

  logic armed;
  logic side0_only;
  logic top_blocks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_comb begin
    side0_only = 1'b1;
    for (int s = 0; s < int'(N_SLOT); s++)
      if ((s % int'(N_SIDE)) != 0 && pr_vld[s]) side0_only = 1'b0;
    for (int k = int'(N_SRC); k < int'(N_OP); k++)
      if (rd_en[k]) side0_only = 1'b0;
    top_blocks = pr_vld[TOP] && !pr_rdy[TOP] && (&pr_ben[TOP*LANES +: LANES]) &&
                 rd_en[0] && (rd_reg[0 +: REG_W] == pr_dst[TOP*REG_W +: REG_W]);
  end

  AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_vld == '0) |-> (opnd == rd_rf && !stall)); // R1

  AST_NO_READ_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en == '0) |-> !stall); // R8

  AST_SAME_SIDE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (side0_only && (pr_vld & ~pr_rdy) == '0) |-> !stall); // R5

  AST_HELD_READY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $stable(pr_vld) && $stable(pr_tag) && $stable(pr_rdy) &&
     (pr_vld & ~pr_rdy) == '0) |-> !stall); // R6

  AST_PENDING_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    top_blocks |-> stall); // R7
endmodule

bind opbyp_merge opbyp_merge_chk #(
  .N_SIDE(N_SIDE), .N_SRC(N_SRC), .REG_W(REG_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_reg(rd_reg), .rd_rf(rd_rf),
  .pr_vld(pr_vld), .pr_dst(pr_dst), .pr_ben(pr_ben), .pr_rdy(pr_rdy),
  .pr_tag(pr_tag), .opnd(opnd), .stall(stall)
);

// File: tb/opbyp_merge_tb_top.sv
module opbyp_merge_tb_top;
  localparam int NS = 2, NR = 3, RW = 6, TW = 4, DW = 64;
  localparam int NOP = NS*NR, NSL = NS*2, NL = DW/8;

  logic clk = 1'b0;
  logic rst_n;
  logic [NOP-1:0]     rd_en;
  logic [NOP*RW-1:0]  rd_reg;
  logic [NOP*DW-1:0]  rd_rf;
  logic [NSL-1:0]     pr_vld, pr_rdy;
  logic [NSL*RW-1:0]  pr_dst;
  logic [NSL*NL-1:0]  pr_ben;
  logic [NSL*DW-1:0]  pr_data;
  logic [NSL*TW-1:0]  pr_tag;
  logic [NOP*DW-1:0]  opnd;
  logic               stall;

  always #5 clk = ~clk;

  opbyp_merge dut_i (.*);

  // bench-side stimulus state
  logic          b_en[NOP];
  logic [RW-1:0] b_reg[NOP];
  logic [DW-1:0] b_rf[NOP];
  logic          b_vld[NSL], b_rdy[NSL];
  logic [RW-1:0] b_dst[NSL];
  logic [NL-1:0] b_ben[NSL];
  logic [DW-1:0] b_dat[NSL];
  logic [TW-1:0] b_tag[NSL];
  // model: tags seen ready at the previous edge
  bit            m_seen[NSL];
  logic [TW-1:0] m_tag[NSL];

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int tag_ctr = 0;

  task automatic apply();
    for (int k = 0; k < NOP; k++) begin
      rd_en[k] = b_en[k];
      rd_reg[k*RW +: RW] = b_reg[k];
      rd_rf[k*DW +: DW] = b_rf[k];
    end
    for (int s = 0; s < NSL; s++) begin
      pr_vld[s] = b_vld[s];
      pr_rdy[s] = b_rdy[s];
      pr_dst[s*RW +: RW] = b_dst[s];
      pr_ben[s*NL +: NL] = b_ben[s];
      pr_data[s*DW +: DW] = b_dat[s];
      pr_tag[s*TW +: TW] = b_tag[s];
    end
  endtask

  task automatic clr();
    for (int k = 0; k < NOP; k++) begin
      b_en[k] = 1'b0; b_reg[k] = RW'(k + 40);
      b_rf[k] = {$urandom, $urandom};
    end
    for (int s = 0; s < NSL; s++) begin
      b_vld[s] = 1'b0; b_rdy[s] = 1'b1; b_dst[s] = '0; b_ben[s] = '0;
      b_dat[s] = {$urandom, $urandom}; b_tag[s] = TW'(s);
    end
  endtask

  function automatic bit prev_ready(int s);
    for (int q = 0; q < NSL; q++)
      if (q % NS == s % NS && m_seen[q] && m_tag[q] == b_tag[s]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string rq);
    // search order: stage0 side1, stage0 side0, stage1 side1, stage1 side0
    int ord[4] = '{1, 0, 3, 2};
    bit exp_stall = 1'b0;
    for (int k = 0; k < NOP; k++) begin
      logic [DW-1:0] ev = b_rf[k];
      bit w = 1'b0;
      for (int b = 0; b < NL; b++) begin
        for (int i = 0; i < NSL; i++) begin
          int s = ord[i];
          if (b_vld[s] && b_ben[s][b] && b_dst[s] == b_reg[k]) begin
            ev[b*8 +: 8] = b_dat[s][b*8 +: 8];
            if (s % NS == k / NR) begin if (!b_rdy[s]) w = 1'b1; end
            else if (!(b_rdy[s] && prev_ready(s))) w = 1'b1;
            break;
          end
        end
      end
      if (b_en[k] && w) exp_stall = 1'b1;
      checks++;
      if (opnd[k*DW +: DW] !== ev) begin
        fails++;
        $display("FAIL %s operand %0d got %h expected %h", rq, k, opnd[k*DW +: DW], ev);
      end
    end
    checks++;
    if (stall !== exp_stall) begin
      fails++;
      $display("FAIL %s stall got %b expected %b", rq, stall, exp_stall);
    end
  endtask

  task automatic capture();
    if (rst_n)
      for (int s = 0; s < NSL; s++) begin
        m_seen[s] = b_vld[s] && b_rdy[s];
        m_tag[s] = b_tag[s];
      end
  endtask

  task automatic cyc(string rq);
    apply();
    #3;
    check(rq);
    @(posedge clk);
    capture();
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    for (int s = 0; s < NSL; s++) begin m_seen[s] = 1'b0; m_tag[s] = '0; end
    clr();
    // R10: EX1 side0 ready, side1 consumer reading it while in reset
    b_vld[0] = 1'b1; b_dst[0] = 6'd12; b_ben[0] = 8'hff; b_tag[0] = 4'd3;
    b_en[NR] = 1'b1; b_reg[NR] = 6'd12;
    apply();
    repeat (2) @(posedge clk);
    #2;
    check("R10");
    rst_n = 1'b1;
    #2;
    check("R10");
    @(posedge clk); capture(); #1;
    cyc("R6");             // held one more cycle: stall released

    // R1: no producers
    clr();
    for (int k = 0; k < NOP; k++) b_en[k] = 1'b1;
    cyc("R1");

    // R2: bytes spread over EX1, WB and the register file
    clr();
    b_vld[0] = 1; b_dst[0] = 6'd5; b_ben[0] = 8'h1a; b_tag[0] = 4'd1;
    b_vld[2] = 1; b_dst[2] = 6'd5; b_ben[2] = 8'h50; b_tag[2] = 4'd2;
    b_en[0] = 1; b_reg[0] = 6'd5;
    cyc("R2");

    // R3: stage priority
    clr();
    b_vld[0] = 1; b_dst[0] = 6'd7; b_ben[0] = 8'hff; b_tag[0] = 4'd4;
    b_vld[2] = 1; b_dst[2] = 6'd7; b_ben[2] = 8'hff; b_tag[2] = 4'd5;
    b_en[1] = 1; b_reg[1] = 6'd7;
    cyc("R3");

    // R4: side priority within a stage, read from side 1 twice
    clr();
    b_vld[0] = 1; b_dst[0] = 6'd9; b_ben[0] = 8'h0f; b_tag[0] = 4'd6;
    b_vld[1] = 1; b_dst[1] = 6'd9; b_ben[1] = 8'h3c; b_tag[1] = 4'd7;
    b_en[NR] = 1; b_reg[NR] = 6'd9;
    cyc("R4");
    cyc("R4");

    // R5: same-side single-cycle result
    clr();
    b_vld[1] = 1; b_dst[1] = 6'd20; b_ben[1] = 8'hff; b_tag[1] = 4'd8;
    b_en[NR+2] = 1; b_reg[NR+2] = 6'd20;
    cyc("R5");

    // R6: cross side, then the result moves to WB
    clr();
    b_vld[1] = 1; b_dst[1] = 6'd21; b_ben[1] = 8'hf0; b_tag[1] = 4'd9;
    b_en[0] = 1; b_reg[0] = 6'd21;
    cyc("R6");
    b_vld[1] = 0; b_vld[3] = 1; b_dst[3] = 6'd21; b_ben[3] = 8'hf0;
    b_dat[3] = b_dat[1]; b_tag[3] = 4'd9;
    cyc("R6");

    // R7: multi-cycle result not ready, then ready, then held
    clr();
    b_vld[2] = 1; b_rdy[2] = 0; b_dst[2] = 6'd30; b_ben[2] = 8'h81; b_tag[2] = 4'd10;
    b_en[2] = 1; b_reg[2] = 6'd30; b_en[NR+1] = 1; b_reg[NR+1] = 6'd30;
    cyc("R7");
    b_rdy[2] = 1;
    cyc("R7");
    cyc("R6");

    // R8: disabled reader of a pending result
    clr();
    b_vld[0] = 1; b_rdy[0] = 0; b_dst[0] = 6'd33; b_ben[0] = 8'hff; b_tag[0] = 4'd11;
    b_reg[0] = 6'd33; b_reg[NR] = 6'd33;
    cyc("R8");

    // R9: register 0 forwarded
    clr();
    b_vld[3] = 1; b_dst[3] = 6'd0; b_ben[3] = 8'h3c; b_tag[3] = 4'd12;
    b_en[NR+1] = 1; b_reg[NR+1] = 6'd0; b_en[0] = 1; b_reg[0] = 6'd0;
    cyc("R9");

    // R11: invalid slot with matching destination
    clr();
    b_vld[0] = 0; b_rdy[0] = 0; b_dst[0] = 6'd44; b_ben[0] = 8'hff;
    b_en[NR] = 1; b_reg[NR] = 6'd44;
    cyc("R11");

    // R2: mixed random traffic, slots held for varied durations
    clr();
    for (int i = 0; i < 600; i++) begin
      for (int k = 0; k < NOP; k++) begin
        b_en[k] = 1'($urandom);
        b_reg[k] = RW'($urandom_range(0, 3));
        b_rf[k] = {$urandom, $urandom};
      end
      if ($urandom_range(0, 1) == 0) begin
        int s = $urandom_range(0, NSL - 1);
        tag_ctr++;
        b_vld[s] = 1'($urandom_range(0, 3) != 0);
        b_rdy[s] = 1'($urandom_range(0, 2) != 0);
        b_dst[s] = RW'($urandom_range(0, 3));
        b_ben[s] = NL'($urandom);
        b_dat[s] = {$urandom, $urandom};
        b_tag[s] = TW'(tag_ctr);
      end else if ($urandom_range(0, 2) == 0) begin
        int s = $urandom_range(0, NSL - 1);
        b_rdy[s] = 1'b1;
      end
      cyc("R2");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule